// File: doc/BRIEF.md
# Embedded Logic Analyzer Trigger Sequencer

This block is an on-chip debug monitor. It watches one observation bus that carries the signals of a bus transaction: a valid qualifier, an address field and a read/write type bit. A sequencer with up to eight trigger states compares the bus against a programmed pattern on every qualified cycle. Each state has its own match value, its own compare mask, its own hit count and its own successor state. When the last state in the chain reaches its hit count, the block raises a halt request toward a cross-trigger network.

While that request is pending, a latency counter counts clock cycles until the halt acknowledge returns. The counter then freezes so that debug software can read it. The block then stays in a done state and ignores the bus until software re-arms it. Software programs the trigger states and re-arms the block through a simple 32-bit register write port. The current state, hit count, done flag and latency are driven straight onto status outputs.

Out of reset the block is already armed for a common case. State 0 watches for valid accesses of either type to address 0xB1000000 and fires on the third one.

Top module: `sigwatch_trigger`

## Requirements
- R1: After reset the halt request is low and the state, hit count, done flag and latency are all 0. State 0 is preloaded to compare the valid bit and address 0xB1000000, to ignore the type bit and every other bit, to need 3 hits and to fire. Every other state is preloaded with an all-zero mask, a count of 1, itself as successor and no fire.
- R2: A cycle whose observation bit 127 (valid) is 0 never counts as a hit, whatever the other bits hold.
- R3: A hit needs `(obs ^ match) & mask == 0` for the current state. The address field is bits 114:75 (40 bits) and the type bit is bit 73. Bits outside the mask have no effect.
- R4: Each hit increments the hit count. When the count reaches the state's programmed count, the hit count returns to 0 and, for a state without the fire flag, the sequencer moves to the programmed successor state.
- R5: At the final hit of a state with the fire flag, the halt request rises on the next clock and the hit count returns to 0. The request stays high until the acknowledge is sampled high.
- R6: The latency equals the number of clock edges at which the halt request was high and the acknowledge low. It freezes when the acknowledge arrives, and at the same edge the done flag sets and the halt request drops.
- R7: The latency saturates at its maximum value (2^LAT_W-1) instead of wrapping.
- R8: In the done state, bus activity changes neither the state, the hit count, the latency nor the halt request.
- R9: A write with address bit 7 = 1 and data bit 0 = 1 re-arms the block. On the next clock the state, hit count, latency and done flag are 0 and the halt request is low. Re-arming takes priority over a hit in the same cycle.
- R10: A programmed hit count of 0 behaves like a count of 1.
- R11: Writes with address bit 7 = 0 select a state with address bits 6:4 and a word with bits 3:0. Words 0-3 are the match value and words 4-7 the mask, 32 bits each, least significant word first. Word 8 is control: bits 7:0 are the count, bits 10:8 the successor state and bit 31 the fire flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| obs_i | input | OBS_W | Observation bus |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 8 | Register write address |
| wr_data_i | input | 32 | Register write data |
| halt_ack_i | input | 1 | Halt acknowledge from the cross-trigger network |
| halt_req_o | output | 1 | Halt request |
| stat_state_o | output | 3 | Current trigger state |
| stat_hits_o | output | CNT_W | Hits counted in the current state |
| stat_done_o | output | 1 | Sequence finished and acknowledged |
| lat_count_o | output | LAT_W | Request-to-acknowledge latency |

## Verification
The bench sweeps hit counts 0 to 4 against acknowledge delays of 0, 1, 3 and 7 cycles.
- An off-by-one in the count compare would fire one hit early or late.
- Mishandling count 0 would never fire.
- A latency counter that is off by one, or that keeps running after the acknowledge, gives a wrong frozen value.

Invalid cycles that carry the target address, single-bit address misses and random noise outside the mask catch a missing qualifier or a wrong mask. A two-state chain catches a wrong successor. A long stall with a narrow counter catches wraparound. Traffic after done and a re-arm in mid-count catch a sequencer that leaks out of its done state or that keeps stale hit counts.

// File: rtl/sigwatch_pkg.sv
package sigwatch_pkg;
    typedef enum logic [1:0] {
        PH_RUN  = 2'd0,
        PH_HALT = 2'd1,
        PH_DONE = 2'd2
    } phase_e;
endpackage

// File: rtl/sigwatch_cfg.sv
module sigwatch_cfg #(
    parameter int          OBS_W     = 128,
    parameter int          NUM_ST    = 8,
    parameter int          CNT_W     = 8,
    parameter int          VALID_BIT = 127,
    parameter int          ADDR_LSB  = 75,
    parameter int          ADDR_W    = 40,
    parameter logic [39:0] DEF_ADDR  = 40'hB1000000,
    parameter int          DEF_CNT   = 3,
    localparam int         ST_W      = $clog2(NUM_ST),
    localparam int         NW        = OBS_W / 32,
    localparam int         SEL_W     = $clog2(2 * NW + 1),
    localparam int         AW        = 1 + ST_W + SEL_W
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              wr_en,
    input  logic [AW-1:0]                     wr_addr,
    input  logic [31:0]                       wr_data,
    output logic [NUM_ST-1:0][OBS_W-1:0]      match_o,
    output logic [NUM_ST-1:0][OBS_W-1:0]      mask_o,
    output logic [NUM_ST-1:0][CNT_W-1:0]      cnt_o,
    output logic [NUM_ST-1:0][ST_W-1:0]       nxt_o,
    output logic [NUM_ST-1:0]                 fire_o,
    output logic                              arm_o
);
    typedef struct packed {
        logic [NUM_ST-1:0][OBS_W-1:0] match;
        logic [NUM_ST-1:0][OBS_W-1:0] mask;
        logic [NUM_ST-1:0][CNT_W-1:0] cnt;
        logic [NUM_ST-1:0][ST_W-1:0]  nxt;
        logic [NUM_ST-1:0]            fire;
    } cfg_t;

    localparam logic [OBS_W-1:0] DEF_MATCH =
        (OBS_W'(1) << VALID_BIT) | (OBS_W'(DEF_ADDR[ADDR_W-1:0]) << ADDR_LSB);
    localparam logic [OBS_W-1:0] DEF_MASK =
        (OBS_W'(1) << VALID_BIT) | (OBS_W'({ADDR_W{1'b1}}) << ADDR_LSB);

    function automatic cfg_t reset_cfg();
        cfg_t c;
        c = '0;
        for (int s = 0; s < NUM_ST; s++) begin
            c.match[s] = (s == 0) ? DEF_MATCH : '0;
            c.mask[s]  = (s == 0) ? DEF_MASK  : '0;
            c.cnt[s]   = (s == 0) ? CNT_W'(DEF_CNT) : CNT_W'(1);
            c.nxt[s]   = ST_W'(s);
            c.fire[s]  = (s == 0);
        end
        return c;
    endfunction

    localparam cfg_t CFG_RST = reset_cfg();

    cfg_t             cfg_d, cfg_q;
    logic [ST_W-1:0]  wst;
    logic [SEL_W-1:0] wsel;

    assign wst  = wr_addr[SEL_W +: ST_W];
    assign wsel = wr_addr[SEL_W-1:0];

    always_comb begin
        cfg_d = cfg_q;
        arm_o = 1'b0;
        if (wr_en) begin
            if (wr_addr[AW-1]) begin
                arm_o = wr_data[0];
            end else if (int'(wst) < NUM_ST) begin
                for (int w = 0; w < NW; w++) begin
                    if (wsel == SEL_W'(w))
                        cfg_d.match[wst][w*32 +: 32] = wr_data;
                    if (wsel == SEL_W'(NW + w))
                        cfg_d.mask[wst][w*32 +: 32] = wr_data;
                end
                if (wsel == SEL_W'(2 * NW)) begin
                    cfg_d.cnt[wst]  = wr_data[CNT_W-1:0];
                    cfg_d.nxt[wst]  = wr_data[8 +: ST_W];
                    cfg_d.fire[wst] = wr_data[31];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= CFG_RST;
        else        cfg_q <= cfg_d;
    end

    assign match_o = cfg_q.match;
    assign mask_o  = cfg_q.mask;
    assign cnt_o   = cfg_q.cnt;
    assign nxt_o   = cfg_q.nxt;
    assign fire_o  = cfg_q.fire;
endmodule

// File: rtl/sigwatch_cmp.sv
module sigwatch_cmp #(
    parameter int OBS_W  = 128,
    parameter int NUM_ST = 8
) (
    input  logic [OBS_W-1:0]              obs,
    input  logic [NUM_ST-1:0][OBS_W-1:0]  match,
    input  logic [NUM_ST-1:0][OBS_W-1:0]  mask,
    output logic [NUM_ST-1:0]             hit_o
);
    for (genvar s = 0; s < NUM_ST; s++) begin : g_state
        assign hit_o[s] = (((obs ^ match[s]) & mask[s]) == '0);
    end
endmodule

// File: rtl/sigwatch_lat.sv
module sigwatch_lat #(
    parameter int LAT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             run,
    output logic [LAT_W-1:0] count_o
);
    localparam logic [LAT_W-1:0] LAT_MAX = '1;

    logic [LAT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clear)                         cnt_d = '0;
        else if (run && cnt_q != LAT_MAX)  cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign count_o = cnt_q;

    // R7
    lat_saturate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == LAT_MAX && !clear) |=> cnt_q == LAT_MAX);
endmodule

// File: rtl/sigwatch_trigger.sv
module sigwatch_trigger
    import sigwatch_pkg::*;
#(
    parameter int          OBS_W     = 128,
    parameter int          NUM_ST    = 8,
    parameter int          CNT_W     = 8,
    parameter int          LAT_W     = 16,
    parameter int          VALID_BIT = 127,
    parameter int          ADDR_LSB  = 75,
    parameter int          ADDR_W    = 40,
    parameter logic [39:0] DEF_ADDR  = 40'hB1000000,
    parameter int          DEF_CNT   = 3,
    localparam int         ST_W      = $clog2(NUM_ST),
    localparam int         NW        = OBS_W / 32,
    localparam int         SEL_W     = $clog2(2 * NW + 1),
    localparam int         AW        = 1 + ST_W + SEL_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [OBS_W-1:0] obs_i,
    input  logic             wr_en_i,
    input  logic [AW-1:0]    wr_addr_i,
    input  logic [31:0]      wr_data_i,
    input  logic             halt_ack_i,
    output logic             halt_req_o,
    output logic [ST_W-1:0]  stat_state_o,
    output logic [CNT_W-1:0] stat_hits_o,
    output logic             stat_done_o,
    output logic [LAT_W-1:0] lat_count_o
);
    typedef struct packed {
        phase_e           phase;
        logic [ST_W-1:0]  state;
        logic [CNT_W-1:0] hits;
    } seq_t;

    logic [NUM_ST-1:0][OBS_W-1:0] match, mask;
    logic [NUM_ST-1:0][CNT_W-1:0] cnt;
    logic [NUM_ST-1:0][ST_W-1:0]  nxt;
    logic [NUM_ST-1:0]            fire;
    logic [NUM_ST-1:0]            hit_vec;
    logic                         arm;
    logic                         hit;
    logic [CNT_W:0]               need;
    logic [CNT_W:0]               hits_inc;
    seq_t                         seq_d, seq_q;

    sigwatch_cfg #(
        .OBS_W(OBS_W), .NUM_ST(NUM_ST), .CNT_W(CNT_W), .VALID_BIT(VALID_BIT),
        .ADDR_LSB(ADDR_LSB), .ADDR_W(ADDR_W), .DEF_ADDR(DEF_ADDR), .DEF_CNT(DEF_CNT)
    ) i_cfg (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en_i), .wr_addr(wr_addr_i),
        .wr_data(wr_data_i), .match_o(match), .mask_o(mask), .cnt_o(cnt),
        .nxt_o(nxt), .fire_o(fire), .arm_o(arm)
    );

    sigwatch_cmp #(.OBS_W(OBS_W), .NUM_ST(NUM_ST)) i_cmp (
        .obs(obs_i), .match(match), .mask(mask), .hit_o(hit_vec)
    );

    assign hit      = obs_i[VALID_BIT] && hit_vec[seq_q.state];
    assign need     = (cnt[seq_q.state] == '0) ? (CNT_W+1)'(1) : {1'b0, cnt[seq_q.state]};
    assign hits_inc = {1'b0, seq_q.hits} + 1'b1;

    always_comb begin
        seq_d = seq_q;
        if (arm) begin
            seq_d = '{phase: PH_RUN, state: '0, hits: '0};
        end else begin
            unique case (seq_q.phase)
                PH_RUN: begin
                    if (hit) begin
                        if (hits_inc >= need) begin
                            seq_d.hits = '0;
                            if (fire[seq_q.state]) seq_d.phase = PH_HALT;
                            else                   seq_d.state = nxt[seq_q.state];
                        end else begin
                            seq_d.hits = hits_inc[CNT_W-1:0];
                        end
                    end
                end
                PH_HALT: begin
                    if (halt_ack_i) seq_d.phase = PH_DONE;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '{phase: PH_RUN, state: '0, hits: '0};
        else        seq_q <= seq_d;
    end

    sigwatch_lat #(.LAT_W(LAT_W)) i_lat (
        .clk(clk), .rst_n(rst_n), .clear(arm),
        .run(seq_q.phase == PH_HALT && !halt_ack_i), .count_o(lat_count_o)
    );

    assign halt_req_o   = (seq_q.phase == PH_HALT);
    assign stat_done_o  = (seq_q.phase == PH_DONE);
    assign stat_state_o = seq_q.state;
    assign stat_hits_o  = seq_q.hits;

    // R2
    invalid_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.phase == PH_RUN && !obs_i[VALID_BIT] && !arm)
            |=> ($stable(stat_state_o) && $stable(stat_hits_o) && !halt_req_o));
    // R5
    halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (halt_req_o && !halt_ack_i && !arm) |=> halt_req_o);
    // R6
    lat_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!halt_req_o && !arm) |=> $stable(lat_count_o));
    // R8
    done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_done_o && !arm)
            |=> (stat_done_o && !halt_req_o && $stable(stat_state_o) && $stable(stat_hits_o)));
    // R9
    rearm_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        arm |=> (stat_state_o == '0 && stat_hits_o == '0 && lat_count_o == '0
                 && !halt_req_o && !stat_done_o));
endmodule

// File: tb/test_sigwatch_trigger.sv
`timescale 1ns/1ps
module test_sigwatch_trigger;
    localparam int LAT_W = 6;
    localparam logic [39:0] TGT = 40'hB1000000;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [127:0] obs_i = '0;
    logic         wr_en_i = 1'b0;
    logic [7:0]   wr_addr_i = '0;
    logic [31:0]  wr_data_i = '0;
    logic         halt_ack_i = 1'b0;
    logic         halt_req_o;
    logic [2:0]   stat_state_o;
    logic [7:0]   stat_hits_o;
    logic         stat_done_o;
    logic [LAT_W-1:0] lat_count_o;

    int nchecks = 0;
    int nerr = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    sigwatch_trigger #(.LAT_W(LAT_W)) i_sigwatch_trigger (
        .clk(clk), .rst_n(rst_n), .obs_i(obs_i), .wr_en_i(wr_en_i),
        .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i), .halt_ack_i(halt_ack_i),
        .halt_req_o(halt_req_o), .stat_state_o(stat_state_o),
        .stat_hits_o(stat_hits_o), .stat_done_o(stat_done_o),
        .lat_count_o(lat_count_o)
    );

    task automatic chk(input string tag, input longint act, input longint exp);
        nchecks++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("  Result: errors=%0d of %0d checks", nerr, nchecks);
            $finish;
        end
    endtask

    function automatic logic [127:0] mkobs(bit v, logic [39:0] a, bit t);
        logic [127:0] w;
        w = {$urandom, $urandom, $urandom, $urandom};
        w[127] = v;
        w[114:75] = a;
        w[73] = t;
        return w;
    endfunction

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
        @(negedge clk);
        wr_en_i = 1'b0;
    endtask

    task automatic step(input logic [127:0] w);
        obs_i = w;
        @(negedge clk);
        obs_i = '0;
    endtask

    task automatic arm();
        wr(8'h80, 32'h1);
    endtask

    task automatic ctrl(input int st, input int n, input int nx, input bit f);
        wr({1'b0, 3'(st), 4'd8}, (32'(n) & 32'hFF) | (32'(nx) << 8) | (32'(f) << 31));
    endtask

    task automatic prog_vec(input int st, input int base, input logic [127:0] v);
        for (int w = 0; w < 4; w++) wr({1'b0, 3'(st), 4'(base + w)}, v[w*32 +: 32]);
    endtask

    task automatic chk_idle(input string tag);
        chk({tag, " state"}, stat_state_o, 0);
        chk({tag, " hits"}, stat_hits_o, 0);
        chk({tag, " lat"}, lat_count_o, 0);
        chk({tag, " halt"}, halt_req_o, 0);
        chk({tag, " done"}, stat_done_o, 0);
    endtask

    initial begin
        #(5.0 * 150000);
        nchecks++; nerr++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        int ne;
        logic [127:0] m, k;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk_idle("R1 reset");

        // R1 default program: third valid hit on target fires
        step(mkobs(1, TGT, 0));
        chk("R1 default hit1", stat_hits_o, 1);
        step(mkobs(1, TGT, 1));
        chk("R1 default hit2", stat_hits_o, 2);
        chk("R1 default no halt yet", halt_req_o, 0);
        step(mkobs(1, TGT, 0));
        chk("R1 default fire", halt_req_o, 1);

        // Sweep hit count N against acknowledge delay D
        for (int n = 0; n <= 4; n++) begin
            for (int di = 0; di < 4; di++) begin
                int d;
                d = (di == 3) ? 7 : di;
                ne = (n == 0) ? 1 : n;
                arm();
                chk_idle("R9 rearm");
                ctrl(0, n, 0, 1);
                for (int i = 0; i < ne; i++) begin
                    step(mkobs(0, TGT, 1));
                    chk("R2 invalid ignored", stat_hits_o, i);
                    step(mkobs(1, TGT ^ (40'd1 << ((i * 7 + di) % 40)), 0));
                    chk("R3 address miss", stat_hits_o, i);
                    step(mkobs(1, TGT, 1'(i)));
                    if (i < ne - 1) begin
                        chk("R4 hit count", stat_hits_o, i + 1);
                        chk("R4 no early halt", halt_req_o, 0);
                    end else begin
                        chk(n == 0 ? "R10 count zero fires" : "R5 halt rises", halt_req_o, 1);
                        chk("R5 hits cleared", stat_hits_o, 0);
                        chk("R6 lat starts", lat_count_o, 0);
                    end
                end
                repeat (d) @(negedge clk);
                chk("R5 halt held", halt_req_o, 1);
                chk("R6 lat before ack", lat_count_o, d);
                halt_ack_i = 1'b1;
                @(negedge clk);
                halt_ack_i = 1'b0;
                chk("R6 halt drops", halt_req_o, 0);
                chk("R6 done set", stat_done_o, 1);
                chk("R6 lat frozen", lat_count_o, d);
                for (int j = 0; j < 3; j++) step(mkobs(1, TGT, 1'(j)));
                chk("R8 done lat", lat_count_o, d);
                chk("R8 done state", stat_state_o, 0);
                chk("R8 done hits", stat_hits_o, 0);
                chk("R8 done halt", halt_req_o, 0);
                chk("R8 done flag", stat_done_o, 1);
            end
        end

        // Two-state chain: state0 x2 -> state5, state5 fires on write to 0x1234
        arm();
        ctrl(0, 2, 5, 0);
        m = '0; m[127] = 1; m[114:75] = 40'h1234; m[73] = 1;
        k = '0; k[127] = 1; k[114:75] = '1; k[73] = 1;
        prog_vec(5, 0, m);
        prog_vec(5, 4, k);
        ctrl(5, 1, 5, 1);
        step(mkobs(1, TGT, 0));
        step(mkobs(1, TGT, 1));
        chk("R4 advance to successor", stat_state_o, 5);
        chk("R4 hits reset on advance", stat_hits_o, 0);
        chk("R11 chain no halt", halt_req_o, 0);
        step(mkobs(1, 40'h1234, 0));
        chk("R3 type mismatch ignored", halt_req_o, 0);
        step(mkobs(1, 40'h1234, 1));
        chk("R5 chain fires", halt_req_o, 1);
        chk("R11 state kept while halting", stat_state_o, 5);

        // Re-arm mid-count, and re-arm wins over a simultaneous hit
        arm();
        ctrl(0, 3, 0, 1);
        step(mkobs(1, TGT, 0));
        step(mkobs(1, TGT, 0));
        chk("R4 mid count", stat_hits_o, 2);
        obs_i = mkobs(1, TGT, 0);
        arm();
        obs_i = '0;
        chk("R9 arm beats hit", stat_hits_o, 0);
        chk("R9 arm beats hit halt", halt_req_o, 0);

        // Saturation
        ctrl(0, 1, 0, 1);
        step(mkobs(1, TGT, 0));
        chk("R7 halt for saturation", halt_req_o, 1);
        repeat (70) @(negedge clk);
        chk("R7 saturated", lat_count_o, 63);
        halt_ack_i = 1'b1;
        @(negedge clk);
        halt_ack_i = 1'b0;
        chk("R7 saturated frozen", lat_count_o, 63);
        chk("R7 done", stat_done_o, 1);

        summary();
    end
endmodule